// File: doc/BRIEF.md
# Digital Video Capture Demultiplexer

This block sits behind an 8-bit parallel digital video input. The stream carries 4:2:2 YUV. Within each pixel pair the bytes arrive as one blue-difference sample, the first luma sample, one red-difference sample and then the second luma sample. Timing reference codes are embedded in the stream. The block finds those codes and tracks where the active part of each line begins and ends. It then sorts the active bytes into three separate sample streams: luma, blue-difference chroma and red-difference chroma. Each stream leaves the block with a valid strobe, a write address local to the line and a first-of-line marker, so that a memory writer can store the three planes independently.

An optional half-width mode drops every second luma sample and the chroma of every second pixel pair. This halves the horizontal resolution during capture, with no processor involvement, and the output stays 4:2:2. A 720-pixel line becomes 360 luma samples and 180 samples in each chroma plane. The subsample enable and the active line length are taken from the configuration inputs once per line, when the start-of-active-video code arrives.

Top module: `vid_cap_demux`

## Requirements
- R1: During and directly after reset, no output strobe is high.
- R2: In full-width mode, the bytes of pixel pair k (byte offsets 0..3 after the start code: Cb, Y0, Cr, Y1) appear on the outputs in the cycle after each byte is presented. The outputs are Cb at chroma address k, Y0 at luma address 2k, Cr at chroma address k, and Y1 at luma address 2k+1.
- R3: A timing code is the four-byte sequence FF, 00, 00, XY, where bit 7 of XY is 1. Bit 4 of XY is 1 for end of active video and 0 for start of active video. Bit 5 of XY is 1 on blanking lines. A start code with bit 5 set, or a candidate code with bit 7 clear, starts no capture.
- R4: After an end-of-active-video code, no strobe rises until the next start code that opens a line.
- R5: Each plane's address restarts at 0 on every line. The line marker is high exactly on a plane's sample at address 0.
- R6: In half-width mode, Y0 of pair k is written to luma address k and Y1 is dropped. Cb and Cr are kept only for even k, at chroma address k/2.
- R7: A sample whose pixel index is at or beyond the latched line length is dropped. The pixel index is 2k for Cb, Y0 and Cr, and 2k+1 for Y1. The line length must be even and no larger than the pixels actually sent.
- R8: At most one of the three strobes is high in any cycle.
- R9: The subsample enable and line length in force for a line are the values present in the cycle of its start code. Changes during the line have no effect until the next start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_byte | input | 8 | Multiplexed video byte stream |
| cfg_subsample | input | 1 | 1 selects the half-width capture mode |
| cfg_line_len | input | LW | Active pixels per line (even) |
| y_valid | output | 1 | Luma sample strobe |
| y_data | output | 8 | Luma sample |
| y_addr | output | LW | Luma write address within the line |
| y_first | output | 1 | Luma sample is the first of its line |
| cb_valid | output | 1 | Blue-difference sample strobe |
| cb_data | output | 8 | Blue-difference sample |
| cb_addr | output | LW | Blue-difference write address within the line |
| cb_first | output | 1 | Blue-difference sample is the first of its line |
| cr_valid | output | 1 | Red-difference sample strobe |
| cr_data | output | 8 | Red-difference sample |
| cr_addr | output | LW | Red-difference write address within the line |
| cr_first | output | 1 | Red-difference sample is the first of its line |

## Verification
The start code has two effects in the same cycle. It latches the configuration for the new line, and the configuration inputs may change in that very cycle. The bench changes the subsample enable and the line length exactly on the start-code byte, and again in the middle of the line. The reference model applies only the value present at the start code, so it expects the new mode for the whole line. A separate case has the line-length cutoff land in the same pixel pair as a kept chroma sample; the model judges each sample by its own pixel index.

// File: rtl/vcd_pkg.sv
// Shared constants for the video capture demultiplexer.
// Assumes the byte order Cb, Y0, Cr, Y1 within each pixel pair.
package vcd_pkg;
    localparam logic [1:0] PH_CB = 2'd0;
    localparam logic [1:0] PH_Y0 = 2'd1;
    localparam logic [1:0] PH_CR = 2'd2;
    localparam logic [1:0] PH_Y1 = 2'd3;

    localparam int NPLANE = 3;
    localparam int PL_Y   = 0;
    localparam int PL_CB  = 1;
    localparam int PL_CR  = 2;
endpackage

// File: rtl/vcd_trs_decode.sv
// Timing reference decoder and line tracker.
// Finds the FF 00 00 XY codes and opens a line on a start code whose
// blanking bit is clear. It latches the per-line configuration and tracks
// the byte phase and pixel pair count of the current line.
// Assumes the configured line length never exceeds the bytes sent, so the
// preamble of the end code falls beyond the cutoff.
module vcd_trs_decode
    import vcd_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    pix_byte,
    input  logic          cfg_subsample,
    input  logic [LW-1:0] cfg_line_len,
    output logic          line_start,
    output logic          data_ok,
    output logic [1:0]    phase,
    output logic [LW-1:0] pair,
    output logic          sub_line
);
    logic [7:0]    hist1, hist2, hist3;
    logic          active;
    logic [LW-1:0] len_line;
    logic          trs_hit;
    logic [LW:0]   pix_idx;

    // Code detect: three previous bytes form the preamble, current byte is XY
    assign trs_hit    = (hist3 == 8'hFF) && (hist2 == 8'h00) && (hist1 == 8'h00) && pix_byte[7];
    assign line_start = trs_hit && !pix_byte[4] && !pix_byte[5];
    // Pixel index of the current byte's sample, used for the cutoff
    assign pix_idx    = {pair, (phase == PH_Y1)};
    assign data_ok    = active && !trs_hit && (pix_idx < {1'b0, len_line});

    // Byte history, line state and configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist1    <= '0;
            hist2    <= '0;
            hist3    <= '0;
            active   <= 1'b0;
            phase    <= PH_CB;
            pair     <= '0;
            sub_line <= 1'b0;
            len_line <= '0;
        end else begin
            hist1 <= pix_byte;
            hist2 <= hist1;
            hist3 <= hist2;
            if (trs_hit) begin
                if (pix_byte[4]) begin
                    active <= 1'b0;
                end else begin
                    active   <= !pix_byte[5];
                    phase    <= PH_CB;
                    pair     <= '0;
                    sub_line <= cfg_subsample;
                    len_line <= cfg_line_len;
                end
            end else if (active) begin
                phase <= phase + 2'd1;
                if (phase == PH_Y1 && pair != '1)
                    pair <= pair + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vcd_sample_route.sv
// Plane selector: decides which plane, if any, keeps the current byte.
// Full mode keeps every byte. Half-width mode keeps Y0 only, and keeps
// chroma only on even pixel pairs.
module vcd_sample_route
    import vcd_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic              data_ok,
    input  logic [1:0]        phase,
    input  logic [LW-1:0]     pair,
    input  logic              sub_line,
    output logic [NPLANE-1:0] keep
);
    logic chroma_pair_ok;

    // Chroma survives unless half-width mode hits an odd pair
    assign chroma_pair_ok = !sub_line || !pair[0];

    // Per-plane keep decision
    always_comb begin
        keep        = '0;
        keep[PL_Y]  = data_ok && ((phase == PH_Y0) || (phase == PH_Y1 && !sub_line));
        keep[PL_CB] = data_ok && (phase == PH_CB) && chroma_pair_ok;
        keep[PL_CR] = data_ok && (phase == PH_CR) && chroma_pair_ok;
    end
endmodule

// File: rtl/vcd_plane_lane.sv
// One output plane: registers the kept byte and its line-local address.
// The address counter clears at each line start; assumes line_start and
// keep are never high in the same cycle.
module vcd_plane_lane #(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          keep,
    input  logic [7:0]    din,
    output logic          valid,
    output logic [7:0]    data,
    output logic [LW-1:0] addr,
    output logic          first
);
    logic [LW-1:0] cnt;

    // Output register and per-line address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            addr  <= '0;
            first <= 1'b0;
            cnt   <= '0;
        end else begin
            valid <= keep;
            if (keep) begin
                data  <= din;
                addr  <= cnt;
                first <= (cnt == '0);
                cnt   <= cnt + 1'b1;
            end
            if (line_start)
                cnt <= '0;
        end
    end
endmodule

// File: rtl/vid_cap_demux.sv
// Top level: timing decode, plane routing and three output lanes.
// Output latency is one cycle from the byte on pix_byte to its strobe.
module vid_cap_demux
    import vcd_pkg::*;
#(
    parameter int MAX_PIX = 2048,
    localparam int LW     = $clog2(MAX_PIX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    pix_byte,
    input  logic          cfg_subsample,
    input  logic [LW-1:0] cfg_line_len,
    output logic          y_valid,
    output logic [7:0]    y_data,
    output logic [LW-1:0] y_addr,
    output logic          y_first,
    output logic          cb_valid,
    output logic [7:0]    cb_data,
    output logic [LW-1:0] cb_addr,
    output logic          cb_first,
    output logic          cr_valid,
    output logic [7:0]    cr_data,
    output logic [LW-1:0] cr_addr,
    output logic          cr_first
);
    logic              line_start, data_ok, sub_line;
    logic [1:0]        phase;
    logic [LW-1:0]     pair;
    logic [NPLANE-1:0] keep;
    logic              vld [NPLANE];
    logic [7:0]        dat [NPLANE];
    logic [LW-1:0]     adr [NPLANE];
    logic              fst [NPLANE];

    vcd_trs_decode #(.LW(LW)) i_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_byte      (pix_byte),
        .cfg_subsample (cfg_subsample),
        .cfg_line_len  (cfg_line_len),
        .line_start    (line_start),
        .data_ok       (data_ok),
        .phase         (phase),
        .pair          (pair),
        .sub_line      (sub_line)
    );

    vcd_sample_route #(.LW(LW)) i_route (
        .data_ok  (data_ok),
        .phase    (phase),
        .pair     (pair),
        .sub_line (sub_line),
        .keep     (keep)
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_lane
        vcd_plane_lane #(.LW(LW)) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_start (line_start),
            .keep       (keep[p]),
            .din        (pix_byte),
            .valid      (vld[p]),
            .data       (dat[p]),
            .addr       (adr[p]),
            .first      (fst[p])
        );
    end

    assign y_valid  = vld[PL_Y];
    assign y_data   = dat[PL_Y];
    assign y_addr   = adr[PL_Y];
    assign y_first  = fst[PL_Y];
    assign cb_valid = vld[PL_CB];
    assign cb_data  = dat[PL_CB];
    assign cb_addr  = adr[PL_CB];
    assign cb_first = fst[PL_CB];
    assign cr_valid = vld[PL_CR];
    assign cr_data  = dat[PL_CR];
    assign cr_addr  = adr[PL_CR];
    assign cr_first = fst[PL_CR];
endmodule

// File: rtl/vcd_cap_checker.sv
// Port-level checker for the capture demultiplexer, attached by bind.
// It decodes the timing codes from the input stream on its own.
module vcd_cap_checker #(
    parameter int LW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    pix_byte,
    input logic          y_valid,
    input logic [LW-1:0] y_addr,
    input logic          y_first,
    input logic          cb_valid,
    input logic [LW-1:0] cb_addr,
    input logic          cb_first,
    input logic          cr_valid,
    input logic [LW-1:0] cr_addr,
    input logic          cr_first
);
    logic [7:0]    c1, c2, c3;
    logic          idle;
    logic [LW-1:0] last_y, last_cb, last_cr;
    logic          code_now;

    assign code_now = (c3 == 8'hFF) && (c2 == 8'h00) && (c1 == 8'h00) && pix_byte[7];

    // Independent tracking of blanking state and last address per plane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1 <= '0; c2 <= '0; c3 <= '0;
            idle    <= 1'b1;
            last_y  <= '0;
            last_cb <= '0;
            last_cr <= '0;
        end else begin
            c1 <= pix_byte; c2 <= c1; c3 <= c2;
            if (code_now)
                idle <= pix_byte[4] || pix_byte[5];
            if (y_valid)  last_y  <= y_addr;
            if (cb_valid) last_cb <= cb_addr;
            if (cr_valid) last_cr <= cr_addr;
        end
    end

    p_one_plane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({y_valid, cb_valid, cr_valid}));

    p_quiet_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !(y_valid || cb_valid || cr_valid));

    p_y_first_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && y_first) |-> (y_addr == '0));

    p_cb_first_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_valid && cb_first) |-> (cb_addr == '0));

    p_y_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && !y_first) |-> (y_addr == LW'(last_y + 1'b1)));

    p_cb_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_valid && !cb_first) |-> (cb_addr == LW'(last_cb + 1'b1)));

    p_cr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_valid && !cr_first) |-> (cr_addr == LW'(last_cr + 1'b1)));
endmodule

bind vid_cap_demux vcd_cap_checker #(.LW(LW)) i_chk (.*);

// File: tb/test_vid_cap_demux.sv
module test_vid_cap_demux;
    localparam int LW = 12;

    typedef struct {
        bit yv;  int ya;  int yd;  bit yf;
        bit cbv; int cba; int cbd; bit cbf;
        bit crv; int cra; int crd; bit crf;
        int req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    pix_byte = 8'h10;
    logic          cfg_subsample = 1'b0;
    logic [LW-1:0] cfg_line_len = '0;
    logic          y_valid, y_first, cb_valid, cb_first, cr_valid, cr_first;
    logic [7:0]    y_data, cb_data, cr_data;
    logic [LW-1:0] y_addr, cb_addr, cr_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] byte_q[$];
    bit         sub_q[$];
    int         len_q[$];
    exp_t       exp_q[$];

    always #4 clk = ~clk;

    vid_cap_demux i_vid_cap_demux (.*);

    function automatic exp_t none(int req);
        exp_t e;
        e = '{default: 0};
        e.req = req;
        return e;
    endfunction

    task automatic push(logic [7:0] b, bit sub, int len, exp_t e);
        byte_q.push_back(b); sub_q.push_back(sub);
        len_q.push_back(len); exp_q.push_back(e);
    endtask

    task automatic check(exp_t e);
        bit bad;
        n_chk++;
        bad = (y_valid !== e.yv) || (cb_valid !== e.cbv) || (cr_valid !== e.crv);
        if (e.yv  && (int'(y_addr)  != e.ya  || int'(y_data)  != e.yd  || y_first  != e.yf))  bad = 1;
        if (e.cbv && (int'(cb_addr) != e.cba || int'(cb_data) != e.cbd || cb_first != e.cbf)) bad = 1;
        if (e.crv && (int'(cr_addr) != e.cra || int'(cr_data) != e.crd || cr_first != e.crf)) bad = 1;
        if (bad) begin
            n_fail++;
            $display("FAIL R%0d t=%0t act y=%0b/%0d/%02h/%0b cb=%0b/%0d/%02h/%0b cr=%0b/%0d/%02h/%0b exp y=%0b/%0d/%02h/%0b cb=%0b/%0d/%02h/%0b cr=%0b/%0d/%02h/%0b",
                     e.req, $time, y_valid, y_addr, y_data, y_first, cb_valid, cb_addr, cb_data, cb_first,
                     cr_valid, cr_addr, cr_data, cr_first, e.yv, e.ya, e.yd, e.yf, e.cbv, e.cba, e.cbd, e.cbf,
                     e.crv, e.cra, e.crd, e.crf);
        end
    endtask

    // One line: blanking, start code, data, end code. Config seen at the
    // start code is (sub_sav, len); mid-line it becomes (sub_mid, len_mid).
    task automatic gen_line(int id, bit vblank, bit code_ok, int npix, int len,
                            bit sub_sav, bit sub_mid, int len_mid, int req);
        bit active;
        exp_t e;
        active = code_ok && !vblank;
        for (int i = 0; i < 4; i++) push(i[0] ? 8'h10 : 8'h80, sub_mid, len_mid, none(4));
        push(8'hFF, sub_mid, len_mid, none(4));
        push(8'h00, sub_mid, len_mid, none(4));
        push(8'h00, sub_mid, len_mid, none(4));
        push(code_ok ? (8'h80 | (vblank ? 8'h20 : 8'h00)) : 8'h00, sub_sav, len, none(4));
        for (int i = 0; i < 2 * npix; i++) begin
            int k, ph, pix, val;
            k = i / 4; ph = i % 4;
            val = 16 + (id * 37 + i * 11) % 200;
            pix = 2 * k + (ph == 3 ? 1 : 0);
            e = none(active ? 7 : req);
            if (active && pix < len) begin
                e.req = req;
                if (!sub_sav) begin
                    if (ph == 1 || ph == 3) begin e.yv = 1; e.ya = pix; e.yd = val; end
                    if (ph == 0) begin e.cbv = 1; e.cba = k; e.cbd = val; end
                    if (ph == 2) begin e.crv = 1; e.cra = k; e.crd = val; end
                end else begin
                    if (ph == 1) begin e.yv = 1; e.ya = k; e.yd = val; end
                    if (ph == 0 && k % 2 == 0) begin e.cbv = 1; e.cba = k / 2; e.cbd = val; end
                    if (ph == 2 && k % 2 == 0) begin e.crv = 1; e.cra = k / 2; e.crd = val; end
                end
                e.yf = e.yv && e.ya == 0;
                e.cbf = e.cbv && e.cba == 0;
                e.crf = e.crv && e.cra == 0;
            end
            push(val[7:0], (i < npix) ? sub_sav : sub_mid, (i < npix) ? len : len_mid, e);
        end
        push(8'hFF, sub_mid, len_mid, none(4));
        push(8'h00, sub_mid, len_mid, none(4));
        push(8'h00, sub_mid, len_mid, none(4));
        push(8'h90 | (vblank ? 8'h20 : 8'h00), sub_mid, len_mid, none(4));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t pend;
        // R1: strobes low while reset is held
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pix_byte = 8'hFF;
            if (i > 0) check(none(1));
        end
        @(negedge clk); rst_n = 1'b1; pix_byte = 8'h10;
        check(none(1));

        // R3: blanking line, and a candidate code with bit 7 clear
        gen_line(1, 1, 1, 8, 8, 0, 0, 8, 3);
        gen_line(2, 0, 0, 8, 8, 0, 0, 8, 3);
        // R2, R5: two full-width lines, addresses restart
        gen_line(3, 0, 1, 8, 8, 0, 0, 8, 2);
        gen_line(4, 0, 1, 8, 8, 0, 0, 8, 5);
        // R6, R9: half-width line, mode raised on the start code byte,
        // dropped and length shrunk mid-line with no effect
        gen_line(5, 0, 1, 12, 12, 1, 0, 2, 6);
        // R9: back to full width on the start code while mid-line says half
        gen_line(6, 0, 1, 8, 8, 0, 1, 2, 9);
        // R7: cutoff at 6 pixels of 12 sent, and at 10 in half-width mode
        gen_line(7, 0, 1, 12, 6, 0, 0, 6, 7);
        gen_line(8, 0, 1, 16, 10, 1, 1, 10, 7);
        // R4: blanking bytes after the end code stay quiet
        for (int i = 0; i < 6; i++) push(8'h55 + 8'(i), 1, 8, none(4));

        pend = none(4);
        while (byte_q.size() > 0) begin
            @(negedge clk);
            check(pend);
            pix_byte      = byte_q.pop_front();
            cfg_subsample = sub_q.pop_front();
            cfg_line_len  = LW'(len_q.pop_front());
            pend          = exp_q.pop_front();
        end
        @(negedge clk);
        check(pend);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule